// File: doc/BRIEF.md
# Alarm Delta Event Register

This block turns a set of receive-side line alarm conditions into sticky change-of-state flags and a single interrupt. Level alarms (such as signal fail, signal degrade, loss of frame, out of frame and loss of input clock) arrive asynchronously. Each is resynchronised, and any transition in either direction sets the flag for that alarm. Pulse events from other monitors, such as a trace mismatch or a new overhead byte value, set their flags directly. The loss-of-signal flag merges two sources: an external loss-of-signal pin, and an internal detector that watches the line data for a long run of identical bits.

Every flag has an enable bit in a mask register, and the interrupt is the OR of the flags that are not masked. Software reaches the flags, the mask and the current alarm levels through a small register port. A mode input chooses how flags are cleared. In read-clear mode, reading the flag register clears what was returned. In write-clear mode, writing ones to the flag register clears those positions.

Top module: `alarm_delta_reg`

## Requirements
- R1: After reset the flag register reads 0, the mask register reads all ones, `irq` is 0 and `reg_rdata` is 0.
- R2: A change of level alarm `alarm_lvl[i]`, rising or falling, sets flag bit 1+i. The flag is set on the third rising clock edge after the input changes (two synchroniser flops, then one flop for the flag). No flag bit is ever set without an event.
- R3: A flag bit stays set until it is cleared, even if its alarm returns to its earlier level.
- R4: Flag bit 0 is set by a change in either direction of the synchronised `los_ext` pin, with the same latency as R2, or by a change of the internal loss-of-signal state.
- R5: The internal loss-of-signal state becomes 1 on the clock edge that samples the LOS_RUN-th consecutive identical value of `line_data`, and returns to 0 on the first edge that samples a different value. A run of LOS_RUN-1 identical samples leaves flag bit 0 clear.
- R6: A one-cycle pulse on `pulse_evt[j]` sets flag bit 1+NUM_LVL+j on the next rising edge.
- R7: Mask bit k = 1 blocks flag k from `irq` but does not stop flag k from being recorded. `irq` is the OR of the flag bits whose mask bit is 0.
- R8: With `clr_mode` = 0 (read-clear), a read of address 0 returns the flags and clears exactly the bits it returned. Writes to address 0 have no effect in this mode.
- R9: With `clr_mode` = 1 (write-clear), a write to address 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. Reads do not clear anything in this mode.
- R10: An event that arrives in the same cycle as a clear of the same bit wins, and the bit ends up set.
- R11: Register map:
  - Address 0 holds the flags.
  - Address 1 holds the mask (read/write).
  - Address 2 holds the status, read-only. Bit 0 is the internal loss-of-signal state OR the synchronised `los_ext`. Bits 1..NUM_LVL are the synchronised level alarms. The pulse positions read 0.
  - Address 3 reads 0.
  - `reg_rdata` is loaded on the edge where `reg_rd` is 1 and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_lvl | input | NUM_LVL | Asynchronous level alarm states |
| los_ext | input | 1 | Asynchronous external loss-of-signal pin |
| line_data | input | 1 | Line data bit, sampled every clock |
| pulse_evt | input | NUM_PULSE | Single-cycle event pulses from other monitors |
| clr_mode | input | 1 | 0 = read-clear, 1 = write-clear |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NUM_BITS | Write data |
| reg_rdata | output | NUM_BITS | Registered read data |
| irq | output | 1 | OR of unmasked flags |

## Verification
The bench builds the block with NUM_LVL = 5, NUM_PULSE = 2 and LOS_RUN = 4, which gives an 8-bit flag register. At this size every flag position can be driven in both directions, masked and unmasked, in both clear modes. The short run length makes it cheap to test the loss-of-signal boundary exactly: a run one sample short of the threshold, and a run that just reaches it. The cycle-exact latencies of the synchronised and pulse paths are checked with reads timed to the edge where each flag appears. The same-cycle collisions between an event and a clear are also checked in both modes.

// File: rtl/ald_pkg.sv
package ald_pkg;

  localparam int ALD_ADDR_W = 2;

  typedef enum logic [ALD_ADDR_W-1:0] {
    ADR_DELTA = 2'd0,
    ADR_MASK  = 2'd1,
    ADR_STAT  = 2'd2,
    ADR_SPARE = 2'd3
  } ald_addr_e;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    CLR_ON_WRITE = 1'b1
  } ald_clr_e;

  // Clear request for one flag, chosen by the clearing mode.
  function automatic logic bit_clear(ald_clr_e mode, logic rd_hit, logic wr_hit,
                                     logic cur, logic wbit);
    if (mode == CLR_ON_WRITE) return wr_hit & wbit;
    return rd_hit & cur;
  endfunction

  // Sticky update: an event overrides a clear in the same cycle.
  function automatic logic bit_next(logic cur, logic set, logic clr);
    return (cur & ~clr) | set;
  endfunction

  // Change-of-state between the present and the registered value.
  function automatic logic toggled(logic now, logic was);
    return now ^ was;
  endfunction

endpackage

// File: rtl/ald_sync.sv
module ald_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/ald_change.sv
module ald_change
  import ald_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chg[i] = toggled(level[i], prev_q[i]);
  end
endmodule

// File: rtl/ald_los_run.sv
module ald_los_run #(
  parameter int LOS_RUN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_data,
  output logic los_int
);
  localparam int CNT_W = $clog2(LOS_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(LOS_RUN);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_n;
  logic             last_q;
  logic             same_bit;

  // Length of the run of identical samples ending with this one, saturating.
  function automatic logic [CNT_W-1:0] run_step(logic [CNT_W-1:0] c, logic same);
    if (!same)        return CNT_W'(1);
    if (c == CNT_CAP) return c;
    return c + CNT_W'(1);
  endfunction

  assign same_bit = (line_data == last_q);
  assign run_n    = run_step(run_q, same_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      last_q  <= 1'b0;
      los_int <= 1'b0;
    end else begin
      run_q   <= run_n;
      last_q  <= line_data;
      los_int <= (run_n == CNT_CAP);
    end
  end
endmodule

// File: rtl/ald_delta_bank.sv
module ald_delta_bank
  import ald_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  ald_clr_e     mode,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic         mask_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] delta_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] clr_vec,
  output logic         irq
);
  logic [N-1:0] delta_d;

  for (genvar b = 0; b < N; b++) begin : g_flag
    assign clr_vec[b] = bit_clear(mode, rd_hit, wr_hit, delta_q[b], wdata[b]);
    assign delta_d[b] = bit_next(delta_q[b], set_vec[b], clr_vec[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
      mask_q  <= '1;
    end else begin
      delta_q <= delta_d;
      if (mask_wr) mask_q <= wdata;
    end
  end

  assign irq = |(delta_q & ~mask_q);
endmodule

// File: rtl/alarm_delta_reg.sv
module alarm_delta_reg
  import ald_pkg::*;
#(
  parameter int NUM_LVL   = 5,
  parameter int NUM_PULSE = 2,
  parameter int LOS_RUN   = 64,
  localparam int NUM_BITS = 1 + NUM_LVL + NUM_PULSE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LVL-1:0]    alarm_lvl,
  input  logic                  los_ext,
  input  logic                  line_data,
  input  logic [NUM_PULSE-1:0]  pulse_evt,
  input  logic                  clr_mode,
  input  logic [ALD_ADDR_W-1:0] reg_addr,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [NUM_BITS-1:0]   reg_wdata,
  output logic [NUM_BITS-1:0]   reg_rdata,
  output logic                  irq
);
  localparam int LOS_POS   = 0;
  localparam int LVL_BASE  = 1;
  localparam int PLS_BASE  = 1 + NUM_LVL;

  logic [NUM_LVL-1:0]  lvl_s;
  logic [NUM_LVL-1:0]  lvl_chg;
  logic                ext_s;
  logic                ext_chg;
  logic                los_int;
  logic                int_chg;
  logic [NUM_BITS-1:0] evt_vec;
  logic [NUM_BITS-1:0] status_vec;
  logic [NUM_BITS-1:0] delta_q;
  logic [NUM_BITS-1:0] mask_q;
  logic [NUM_BITS-1:0] clr_vec;
  logic [NUM_BITS-1:0] rd_mux;
  logic                rd_delta;
  logic                wr_delta;
  logic                mask_wr;
  ald_clr_e            mode;

  ald_sync #(.W(NUM_LVL)) u_lvl_sync (
    .clk(clk), .rst_n(rst_n), .d_async(alarm_lvl), .q_sync(lvl_s)
  );
  ald_sync #(.W(1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_async(los_ext), .q_sync(ext_s)
  );
  ald_change #(.W(NUM_LVL)) u_lvl_chg (
    .clk(clk), .rst_n(rst_n), .level(lvl_s), .chg(lvl_chg)
  );
  ald_change #(.W(1)) u_ext_chg (
    .clk(clk), .rst_n(rst_n), .level(ext_s), .chg(ext_chg)
  );
  ald_los_run #(.LOS_RUN(LOS_RUN)) u_los_run (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .los_int(los_int)
  );
  ald_change #(.W(1)) u_int_chg (
    .clk(clk), .rst_n(rst_n), .level(los_int), .chg(int_chg)
  );

  // Event and status vectors in flag-register order.
  assign evt_vec[LOS_POS]    = ext_chg | int_chg;
  assign status_vec[LOS_POS] = ext_s | los_int;
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    assign evt_vec[LVL_BASE+i]    = lvl_chg[i];
    assign status_vec[LVL_BASE+i] = lvl_s[i];
  end
  for (genvar j = 0; j < NUM_PULSE; j++) begin : g_pls
    assign evt_vec[PLS_BASE+j]    = pulse_evt[j];
    assign status_vec[PLS_BASE+j] = 1'b0;
  end

  assign mode     = ald_clr_e'(clr_mode);
  assign rd_delta = reg_rd && (ald_addr_e'(reg_addr) == ADR_DELTA);
  assign wr_delta = reg_wr && (ald_addr_e'(reg_addr) == ADR_DELTA);
  assign mask_wr  = reg_wr && (ald_addr_e'(reg_addr) == ADR_MASK);

  ald_delta_bank #(.N(NUM_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_vec), .mode(mode),
    .rd_hit(rd_delta), .wr_hit(wr_delta), .mask_wr(mask_wr),
    .wdata(reg_wdata), .delta_q(delta_q), .mask_q(mask_q),
    .clr_vec(clr_vec), .irq(irq)
  );

  always_comb begin
    case (ald_addr_e'(reg_addr))
      ADR_DELTA: rd_mux = delta_q;
      ADR_MASK:  rd_mux = mask_q;
      ADR_STAT:  rd_mux = status_vec;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ald_checker.sv
module ald_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] delta_q,
  input logic [N-1:0] evt_vec,
  input logic [N-1:0] clr_vec,
  input logic         ext_chg,
  input logic         mask_wr,
  input logic         clr_mode,
  input logic         rd_hit,
  input logic         wr_hit,
  input logic         irq
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_vec) & ~delta_q) == '0)); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((delta_q & ~$past(delta_q) & ~$past(evt_vec)) == '0)); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(delta_q) & ~$past(clr_vec) & ~delta_q) == '0)); // R3

  AST_EXT_LOS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ext_chg |=> delta_q[0]); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_vec) != '0 || $past(mask_wr))); // R7

  AST_COR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_mode && !rd_hit) |-> (clr_vec == '0)); // R8

  AST_COW_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && !wr_hit) |-> (clr_vec == '0)); // R9

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & clr_vec) != '0) |=> (($past(evt_vec) & $past(clr_vec) & ~delta_q) == '0)); // R10
endmodule

bind alarm_delta_reg ald_checker #(.N(NUM_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .delta_q(delta_q), .evt_vec(evt_vec),
  .clr_vec(clr_vec), .ext_chg(ext_chg), .mask_wr(mask_wr),
  .clr_mode(clr_mode), .rd_hit(rd_delta), .wr_hit(wr_delta), .irq(irq)
);

// File: tb/alarm_delta_reg_test.sv
module alarm_delta_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;
  localparam int NP = 2;
  localparam int RUN = 4;
  localparam int NB = 1 + NL + NP;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] lvl;
  logic          los_ext;
  logic          line_data;
  logic [NP-1:0] pulse;
  logic          clr_mode;
  logic [1:0]    reg_addr;
  logic          reg_rd;
  logic          reg_wr;
  logic [NB-1:0] reg_wdata;
  logic [NB-1:0] rdata;
  logic          irq;
  logic          alt;
  logic [NB-1:0] d;
  int            checks;
  int            fails;
  bit            done;

  alarm_delta_reg #(.NUM_LVL(NL), .NUM_PULSE(NP), .LOS_RUN(RUN)) uut (
    .clk(clk), .rst_n(rst_n), .alarm_lvl(lvl), .los_ext(los_ext),
    .line_data(line_data), .pulse_evt(pulse), .clr_mode(clr_mode),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (alt) line_data = ~line_data;
  endtask

  task automatic chk(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [NB-1:0] v);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NB-1:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  // Fire the event that belongs to flag position pos; one edge passes.
  task automatic fire(input int pos);
    if (pos == 0)       los_ext = ~los_ext;
    else if (pos <= NL) lvl[pos-1] = ~lvl[pos-1];
    else                pulse[pos-1-NL] = 1'b1;
    tick();
    pulse = '0;
  endtask

  function automatic logic [NB-1:0] stat_exp(logic los_bit);
    return {{NP{1'b0}}, lvl, los_bit};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; lvl = '0; los_ext = 1'b0; line_data = 1'b0; alt = 1'b1;
    pulse = '0; clr_mode = 1'b0; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    reg_wdata = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", {{(NB-1){1'b0}}, irq}, '0);
    chk("R1 rdata", rdata, '0);
    rd(2'd0, d); chk("R1 delta", d, '0);
    rd(2'd1, d); chk("R1 mask", d, '1);
    rd(2'd3, d); chk("R11 spare addr", d, '0);

    // R2 level sweep, both directions, exact latency, read-clear (R8)
    wr(2'd1, '0);
    rd(2'd1, d); chk("R11 mask readback", d, '0);
    for (int i = 0; i < NL; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        lvl[i] = (dir == 0);
        tick(); tick();
        chk("R2 no flag yet irq", {{(NB-1){1'b0}}, irq}, '0);
        rd(2'd0, d); chk("R2 read at set edge", d, '0);
        chk("R7 irq raised", {{(NB-1){1'b0}}, irq}, 1);
        rd(2'd0, d); chk("R2 flag position", d, NB'(1) << (1 + i));
        chk("R8 irq after read", {{(NB-1){1'b0}}, irq}, '0);
        rd(2'd0, d); chk("R8 cleared by read", d, '0);
      end
    end

    // R7 mask sweep over every flag position, plus R4 (pos 0) and R6 (pulses)
    for (int pos = 0; pos < NB; pos++) begin
      for (int m = 0; m < 2; m++) begin
        wr(2'd1, (m == 1) ? (NB'(1) << pos) : ~(NB'(1) << pos));
        fire(pos);
        tick(); tick(); tick();
        chk(m == 1 ? "R7 masked irq" : "R7 unmasked irq",
            {{(NB-1){1'b0}}, irq}, (m == 1) ? '0 : NB'(1));
        rd(2'd0, d);
        chk(pos == 0 ? "R4 external los flag" : "R7 flag recorded", d, NB'(1) << pos);
      end
    end
    wr(2'd1, '0);

    // R6 pulse latency: flag on the very next edge
    chk("R6 idle irq", {{(NB-1){1'b0}}, irq}, '0);
    pulse[1] = 1'b1; tick(); pulse = '0;
    chk("R6 irq next edge", {{(NB-1){1'b0}}, irq}, 1);
    rd(2'd0, d); chk("R6 pulse flag", d, NB'(1) << (NL + 2));

    // R3 sticky across return to old level
    lvl[0] = ~lvl[0]; repeat (4) tick();
    lvl[0] = ~lvl[0]; repeat (4) tick();
    rd(2'd0, d); chk("R3 sticky", d, NB'(2));
    rd(2'd0, d); chk("R3 cleared", d, '0);

    // R11 status register
    lvl = 5'b10110; los_ext = 1'b1; repeat (4) tick();
    rd(2'd2, d); chk("R11 status", d, stat_exp(1'b1));
    los_ext = 1'b0; repeat (4) tick();
    rd(2'd2, d); chk("R11 status los off", d, stat_exp(1'b0));
    rd(2'd0, d); rd(2'd0, d); chk("R4 delta drained", d, '0);

    // R5 internal loss of signal, one sample short of the run
    alt = 1'b0; tick(); tick(); alt = 1'b1; tick();
    repeat (8) tick();
    rd(2'd0, d); chk("R5 short run", d, '0);
    // R5 run that just reaches LOS_RUN
    alt = 1'b0; tick(); tick(); tick(); alt = 1'b1; tick();
    repeat (8) tick();
    rd(2'd0, d); chk("R5 run reached", d, NB'(1));
    rd(2'd0, d); chk("R5 cleared", d, '0);
    // R5 long hold shows in status, then drops on a differing sample
    alt = 1'b0; repeat (8) tick();
    rd(2'd2, d); chk("R5 status held", d, stat_exp(1'b1));
    alt = 1'b1; repeat (8) tick();
    rd(2'd2, d); chk("R5 status released", d, stat_exp(1'b0));
    rd(2'd0, d); chk("R5 both edges flag", d, NB'(1));

    // R8 writes ignored in read-clear mode
    fire(NL + 1);
    wr(2'd0, '1);
    rd(2'd0, d); chk("R8 write ignored", d, NB'(1) << (NL + 1));
    rd(2'd0, d); chk("R8 drained", d, '0);

    // R9 write-clear mode
    clr_mode = 1'b1;
    pulse = 2'b11; tick(); pulse = '0;
    rd(2'd0, d); chk("R9 both set", d, 8'hC0);
    rd(2'd0, d); chk("R9 read keeps", d, 8'hC0);
    wr(2'd0, 8'h40);
    rd(2'd0, d); chk("R9 write one clears", d, 8'h80);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R9 write zero keeps", d, 8'h80);
    wr(2'd0, '1);
    rd(2'd0, d); chk("R9 all cleared", d, '0);

    // R10 event beats write-clear
    fire(NL + 1);
    pulse[0] = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h40; reg_wr = 1'b1;
    tick();
    pulse = '0; reg_wr = 1'b0;
    rd(2'd0, d); chk("R10 write-clear collision", d, 8'h40);
    wr(2'd0, 8'h40);
    rd(2'd0, d); chk("R10 cleared after", d, '0);

    // R10 event beats read-clear
    clr_mode = 1'b0;
    fire(NL + 1);
    pulse[0] = 1'b1; reg_addr = 2'd0; reg_rd = 1'b1;
    tick();
    pulse = '0; reg_rd = 1'b0;
    chk("R10 read returns flag", rdata, 8'h40);
    rd(2'd0, d); chk("R10 read-clear collision", d, 8'h40);
    rd(2'd0, d); chk("R10 drained", d, '0);

    report();
  end
endmodule